// File: doc/BRIEF.md
# Fractional Pulse-Swallowing Clock Enable Divider

This block derives a clock-enable stream from its parent clock. Time is cut into frames of 32 parent cycles. In each frame an accumulator lets through `mult` of the 32 cycles, spread as evenly as the ratio allows, and swallows the rest. A fixed integer post-divider then keeps one of every `FIXED_DIV` surviving pulses. The average enable rate is therefore parent × mult / 32 / FIXED_DIV.

Software writes a 5-bit ratio code. The code holds 32 minus the wanted multiplier, so code 0 gives full rate and code 31 gives 1/32. A written code is only staged. To make it take effect, software sets a request bit, the top bit of the control word. The block moves the staged code into the active ratio at the next frame boundary and clears the request bit in the same edge. Software polls that bit to learn that the change is done. While the request is pending, the block ignores new ratio codes.

A build parameter places the ratio code at a chosen bit offset. A second build parameter places it either in the control word, beside the request bit, or in a separate ratio word.

Top module: `frac_swallow_div`

## Requirements
- R1: After reset, the request bit reads 0, the staged ratio code reads 0, and the enable runs at full rate (mult = 32).
- R2: With active code v, mult = 32 − v. Over any two whole frames (64 parent cycles) with FIXED_DIV = 2, `clk_en` is high in exactly mult cycles. In general, each frame carries exactly mult swallow pulses before the post-divider.
- R3: The end codes behave as stated: code 31 gives one enable per two frames with FIXED_DIV = 2, and code 0 gives one enable every FIXED_DIV cycles.
- R4: Writing address 0 with bit 31 = 1 sets the request bit. It reads back as 1 at bit 31 of address 0 from the next cycle until the change has been applied.
- R5: The block clears the request bit at the first frame boundary after it was set, so the bit stays high for at most 32 cycles.
- R6: While the request bit is 1, writes to the ratio code are ignored. The staged code keeps its value.
- R7: Writing a ratio code without a request does not change the enable rate. The staged code reads back at bits FIELD_LSB+4..FIELD_LSB.
- R8: The active ratio changes only at a frame boundary. Two completed requests therefore finish a whole number of 32-cycle frames apart.
- R9: Swallow pulses are spread evenly. With code 16 and FIXED_DIV = 2, consecutive enables are exactly 4 cycles apart.
- R10: With SHARED_REG = 1, the ratio code sits in address 0 beside the request bit. One write can stage the code and request the change, and writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: 0 is control, 1 is ratio |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Combinational read data |
| clk_en | output | 1 | Divided clock-enable output |

## Verification
Three things can fall in the same clock edge: the frame wrap that applies a pending request, a software write of a new ratio code, and the write that sets the request. The bench writes a new code in the cycle right after setting the request. Depending on the frame phase, that write can land on the very edge where the request is applied. The bench then requires that the readback still shows the earlier code, and that the measured enable count matches the earlier code. The request-completion times are compared modulo 32 to show that a change never lands inside a frame.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
    localparam int FRAME_LEN = 32;
    localparam int FRAME_W   = $clog2(FRAME_LEN);
    localparam int CODE_W    = 5;
    localparam int MULT_W    = CODE_W + 1;
    localparam int REG_W     = 32;
    localparam int REQ_BIT   = 31;
    localparam int CTRL_ADDR  = 0;
    localparam int RATIO_ADDR = 1;

    typedef logic [CODE_W-1:0]  ratio_code_t;
    typedef logic [MULT_W-1:0]  mult_t;
    typedef logic [FRAME_W-1:0] frame_pos_t;

    typedef struct packed {
        frame_pos_t pos;
        logic       wrap;
    } frame_t;

    typedef struct packed {
        logic        req;
        ratio_code_t code;
    } ctrl_state_t;

    function automatic mult_t code_to_mult(input ratio_code_t c);
        return mult_t'(FRAME_LEN) - mult_t'(c);
    endfunction
endpackage

// File: rtl/fsd_regs.sv
module fsd_regs
    import fsd_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FIELD_LSB  = 8,
    parameter bit SHARED_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              apply,
    output logic [REG_W-1:0]  rd_data,
    output ctrl_state_t       state
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_RATIO = ADDR_W'(RATIO_ADDR);
    localparam logic [ADDR_W-1:0] A_CODE  = SHARED_REG ? A_CTRL : A_RATIO;

    logic code_we;
    logic req_set;

    always_comb begin
        code_we = wr_en && (wr_addr == A_CODE) && !state.req;
        req_set = wr_en && (wr_addr == A_CTRL) && wr_data[REQ_BIT] && !state.req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else begin
            if (code_we)
                state.code <= wr_data[FIELD_LSB +: CODE_W];
            if (apply)
                state.req <= 1'b0;
            else if (req_set)
                state.req <= 1'b1;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL)
            rd_data[REQ_BIT] = state.req;
        if (rd_addr == A_CODE)
            rd_data[FIELD_LSB +: CODE_W] = state.code;
    end
endmodule

// File: rtl/fsd_frame.sv
module fsd_frame
    import fsd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  ctrl_state_t state,
    output frame_t      frame,
    output logic        apply,
    output ratio_code_t active
);
    frame_pos_t pos_q;

    always_comb begin
        frame.pos  = pos_q;
        frame.wrap = (pos_q == frame_pos_t'(FRAME_LEN - 1));
        apply      = state.req && frame.wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            active <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
            if (apply)
                active <= state.code;
        end
    end
endmodule

// File: rtl/fsd_accum.sv
module fsd_accum
    import fsd_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mult_t mult,
    input  logic  wrap,
    output logic  pulse
);
    logic [MULT_W:0] acc_q;
    logic [MULT_W:0] sum;

    always_comb begin
        sum   = acc_q + (MULT_W+1)'(mult);
        pulse = (sum >= (MULT_W+1)'(FRAME_LEN));
    end

    always_ff @(posedge clk) begin
        if (rst || wrap)
            acc_q <= '0;
        else
            acc_q <= pulse ? sum - (MULT_W+1)'(FRAME_LEN) : sum;
    end
endmodule

// File: rtl/fsd_postdiv.sv
module fsd_postdiv #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse,
    output logic en
);
    generate
        if (DIV <= 1) begin : g_pass
            assign en = pulse;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_q;

            assign en = pulse && (cnt_q == LAST);

            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q <= '0;
                else if (pulse)
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/frac_swallow_div.sv
module frac_swallow_div
    import fsd_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int FIELD_LSB  = 8,
    parameter int FIXED_DIV  = 2,
    parameter bit SHARED_REG = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              clk_en
);
    ctrl_state_t ctrl_state;
    frame_t      frame;
    logic        apply;
    ratio_code_t active_code;
    mult_t       active_mult;
    logic        swallow_pulse;

    fsd_regs #(
        .ADDR_W(ADDR_W), .FIELD_LSB(FIELD_LSB), .SHARED_REG(SHARED_REG)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .apply(apply),
        .rd_data(rd_data), .state(ctrl_state)
    );

    fsd_frame u_frame (
        .clk(clk), .rst(rst), .state(ctrl_state),
        .frame(frame), .apply(apply), .active(active_code)
    );

    assign active_mult = code_to_mult(active_code);

    fsd_accum u_accum (
        .clk(clk), .rst(rst), .mult(active_mult),
        .wrap(frame.wrap), .pulse(swallow_pulse)
    );

    fsd_postdiv #(.DIV(FIXED_DIV)) u_post (
        .clk(clk), .rst(rst), .pulse(swallow_pulse), .en(clk_en)
    );
endmodule

// File: rtl/frac_swallow_div_chk.sv
module frac_swallow_div_chk
    import fsd_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req,
    input ratio_code_t staged,
    input ratio_code_t active,
    input frame_pos_t  pos,
    input mult_t       mult,
    input logic        pulse
);
    logic [MULT_W:0] pcnt;
    logic [6:0]      req_age;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt    <= '0;
            req_age <= '0;
        end else begin
            pcnt    <= (pos == frame_pos_t'(FRAME_LEN - 1)) ? '0 : pcnt + (MULT_W+1)'(pulse);
            req_age <= req ? req_age + 1'b1 : '0;
        end
    end

    assert_frame_pulses_R2: assert property (@(posedge clk) disable iff (rst)
        (pos == frame_pos_t'(FRAME_LEN - 1)) |-> (pcnt + (MULT_W+1)'(pulse)) == (MULT_W+1)'(mult));

    assert_req_applies_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> (active == staged));

    assert_req_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        req_age <= 7'd32);

    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        req |=> $stable(staged));

    assert_frame_edge_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(active) |-> (pos == '0));
endmodule

bind frac_swallow_div frac_swallow_div_chk u_chk (
    .clk(clk), .rst(rst), .req(ctrl_state.req), .staged(ctrl_state.code),
    .active(active_code), .pos(frame.pos), .mult(active_mult), .pulse(swallow_pulse)
);

// File: tb/frac_swallow_div_tb.sv
module frac_swallow_div_tb;
    localparam int PERIOD = 10;
    localparam int AW = 4;

    typedef struct {
        string req;
        int    cnt;
        int    gap;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd0, rd1;
    logic          en0, en1;
    logic          sel = 1'b0;

    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    exp_t exp_q[$];
    event mon_go, mon_done;

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    frac_swallow_div #(.ADDR_W(AW), .FIELD_LSB(8), .FIXED_DIV(2), .SHARED_REG(1'b0)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en && !sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd0), .clk_en(en0));

    frac_swallow_div #(.ADDR_W(AW), .FIELD_LSB(8), .FIXED_DIV(2), .SHARED_REG(1'b1)) u_dut_shr (
        .clk(clk), .rst(rst), .wr_en(wr_en && sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd1), .clk_en(en1));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        wr_en = 1'b1; wr_addr = AW'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        rd_addr = AW'(addr);
        #1;
        data = sel ? rd1 : rd0;
    endtask

    task automatic wait_req(output int n);
        logic [31:0] d;
        n = 0;
        rd(0, d);
        while (d[31] && n < 40) begin
            @(negedge clk);
            n++;
            rd(0, d);
        end
    endtask

    task automatic measure(input string req, input int cnt, input int gap);
        exp_t e;
        e.req = req; e.cnt = cnt; e.gap = gap;
        exp_q.push_back(e);
        -> mon_go;
        @(mon_done);
    endtask

    // monitor: counts enables over two frames, compares with queued item
    initial begin
        forever begin
            int   n, g, mg;
            bit   seen;
            exp_t e;
            @(mon_go);
            n = 0; g = 0; mg = 0; seen = 0;
            for (int i = 0; i < 64; i++) begin
                g++;
                if (sel ? en1 : en0) begin
                    if (seen && g > mg) mg = g;
                    seen = 1; g = 0; n++;
                end
                @(negedge clk);
            end
            e = exp_q.pop_front();
            chk(e.req, n, e.cnt);
            if (e.gap != 0) chk({e.req, " gap"}, mg, e.gap);
            -> mon_done;
        end
    end

    initial begin
        #(PERIOD * 150000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n, t1, t2;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        rd(0, d); chk("R1 request", int'(d[31]), 0);
        rd(1, d); chk("R1 code", int'(d[12:8]), 0);
        measure("R1", 32, 2);

        wr(1, 32'd16 << 8);
        rd(1, d); chk("R7 staged readback", int'(d[12:8]), 16);
        measure("R7", 32, 2);

        wr(0, 32'h8000_0000);
        rd(0, d); chk("R4 request set", int'(d[31]), 1);
        wait_req(n); t1 = cyc;
        chk("R5 latency", int'(n <= 32), 1);
        measure("R2 R9", 16, 4);

        wr(1, 32'd31 << 8);
        wr(0, 32'h8000_0000);
        wr(1, 32'd5 << 8);
        wait_req(n); t2 = cyc;
        chk("R5 latency", int'(n <= 32), 1);
        rd(1, d); chk("R6 busy ignore", int'(d[12:8]), 31);
        chk("R8 frame aligned", (t2 - t1) % 32, 0);
        measure("R3 code31", 1, 0);

        wr(1, 32'd0);
        wr(0, 32'h8000_0000);
        wait_req(n);
        measure("R3 code0", 32, 2);

        wr(1, 32'd28 << 8);
        wr(0, 32'h8000_0000);
        wait_req(n);
        measure("R2 code28", 4, 0);

        sel = 1'b1;
        rd(0, d); chk("R10 shared reset code", int'(d[12:8]), 0);
        wr(1, 32'd9 << 8);
        rd(1, d); chk("R10 addr1 ignored", int'(d), 0);
        rd(0, d); chk("R10 addr1 no effect", int'(d[12:8]), 0);
        wr(0, 32'h8000_0000 | (32'd24 << 8));
        rd(0, d); chk("R10 request set", int'(d[31]), 1);
        wait_req(n);
        rd(0, d); chk("R10 code readback", int'(d[12:8]), 24);
        measure("R10", 8, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule